// File: doc/BRIEF.md
# Hardware Cursor Clip and Position Unit

This block turns a requested cursor placement into the values a display pipeline needs to draw a small hardware cursor. It takes a signed cursor position, the bitmap width and height, and the active display size. It works out which part of the cursor rectangle is on screen: where it starts on screen, how wide and tall the visible part is, and where in the bitmap display begins. When the display scans interlaced fields, the vertical values are halved and the bitmap row stride is doubled.

A new placement is requested with a single-cycle strobe. Requests for a bitmap that is too large are rejected. A request that leaves nothing visible, or that has no image behind it, turns the cursor off at once and cancels any update still waiting. A visible request is held until the next frame-done strobe, which moves the packed position and size words to the pipeline outputs and turns the cursor on. When the visible size differs from the size armed last, the cursor goes off at once and a reload request is raised, so that bitmap memory can be refilled before the new values take effect.

Top module: `cursor_clip_top`

## Requirements
- R1: When x is negative, the bitmap x offset is -x, the screen x is 0, and the visible width is the bitmap width minus min(-x, width).
- R2: When x is not negative and x plus width exceeds the active width, the visible width is the active width minus x, floored at 0. The x offset is 0. A cursor that ends exactly on the last column is not clipped.
- R3: The rules of R1 and R2 apply vertically, with y, the bitmap height and the active line count giving the y offset, screen y and visible height.
- R4: When interlaced is 1, the screen y and the visible height after clipping are both halved (rounded down), and bmp_stride is twice the bitmap width. Otherwise bmp_stride equals the bitmap width.
- R5: A request with img_present 0, or with a visible width or height of 0 (after R4), clears hw_enable and upd_pending on the next edge.
- R6: With img_present 1, a bitmap larger than 64 in either dimension, or larger than 32 in both, is rejected. size_reject pulses for one cycle, and hw_pos, hw_size, hw_enable and upd_pending keep their values.
- R7: hw_pos carries screen y in bits [31:16] and screen x in bits [15:0]. hw_size carries the visible height in bits [31:16] and the visible width in bits [15:0].
- R8: An accepted visible request sets upd_pending and leaves hw_pos and hw_size unchanged. The first frame_done while upd_pending is 1 loads the armed words into hw_pos and hw_size, sets hw_enable and clears upd_pending. frame_done with nothing pending changes nothing.
- R9: If an accepted visible request's packed size differs from the size armed last (0 after reset), hw_enable clears on the next edge and reload_req pulses for one cycle. An unchanged size raises no reload and leaves hw_enable unchanged.
- R10: When a request and a frame_done with a pending update arrive on the same edge, the previously armed words are committed to hw_pos and hw_size first. The request then decides hw_enable and upd_pending: a disable request clears both, and a resized request leaves hw_enable 0 and upd_pending 1.
- R11: After reset, hw_pos, hw_size, bmp_xoff, bmp_yoff and bmp_stride are 0, and hw_enable, upd_pending, reload_req and size_reject are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Single-cycle request strobe for a new placement |
| img_present | input | 1 | A cursor image is loaded |
| interlaced | input | 1 | Scan-out uses interlaced fields |
| cur_x | input | POS_W | Signed cursor x position |
| cur_y | input | POS_W | Signed cursor y position |
| bmp_w | input | DIM_W | Bitmap width in pixels |
| bmp_h | input | DIM_W | Bitmap height in lines |
| act_w | input | ACT_W | Active display width |
| act_h | input | ACT_W | Active display line count |
| frame_done | input | 1 | Frame-done strobe from the display timing |
| hw_pos | output | 32 | Committed packed screen position |
| hw_size | output | 32 | Committed packed visible size |
| hw_enable | output | 1 | Cursor drawing enable |
| upd_pending | output | 1 | An armed update is waiting for frame_done |
| reload_req | output | 1 | One-cycle pulse: bitmap memory must be refilled |
| size_reject | output | 1 | One-cycle pulse: request rejected as oversized |
| bmp_xoff | output | POS_W | Bitmap x offset of the last armed request |
| bmp_yoff | output | POS_W | Bitmap y offset of the last armed request |
| bmp_stride | output | DIM_W+1 | Bitmap row stride of the last armed request |

## Verification
The commit on frame_done and the handling of a new request can land on the same clock edge. That is the case where the order of their effects matters. The bench provokes it twice. First it raises a resized request in the same cycle as frame_done while an earlier request is armed. It then expects the earlier words on hw_pos and hw_size, with hw_enable low, upd_pending high and a reload pulse. Second it pairs a disable request with frame_done. It then expects the earlier words committed, but the cursor off and nothing pending.

// File: rtl/cursor_clip_pkg.sv
package cursor_clip_pkg;

    localparam int PACK_W = 16;

    typedef struct packed {
        logic [PACK_W-1:0] row;
        logic [PACK_W-1:0] col;
    } pos_word_t;

    typedef struct packed {
        logic [PACK_W-1:0] lines;
        logic [PACK_W-1:0] pixels;
    } size_word_t;

    typedef enum logic [1:0] {
        REQ_IDLE    = 2'd0,
        REQ_REJECT  = 2'd1,
        REQ_DISABLE = 2'd2,
        REQ_ARM     = 2'd3
    } req_kind_t;

    function automatic logic dims_fit(input int unsigned w, input int unsigned h,
                                      input int unsigned max_side, input int unsigned narrow);
        return (w <= max_side) && (h <= max_side) && !((w > narrow) && (h > narrow));
    endfunction

endpackage

// File: rtl/cursor_axis_clip.sv
module cursor_axis_clip #(
    parameter int POS_W = 16,
    parameter int DIM_W = 7,
    parameter int ACT_W = 12
) (
    input  logic signed [POS_W-1:0] pos,
    input  logic [DIM_W-1:0]        dim,
    input  logic [ACT_W-1:0]        act,
    output logic [POS_W-1:0]        skip,
    output logic [POS_W-1:0]        start,
    output logic [DIM_W-1:0]        vis
);
    localparam int EW = ((POS_W > ACT_W) ? POS_W : ACT_W) + 2;

    logic signed [EW-1:0] p_e, d_e, a_e, neg_e, rem_e;

    always_comb begin
        p_e   = {{(EW-POS_W){pos[POS_W-1]}}, pos};
        d_e   = {{(EW-DIM_W){1'b0}}, dim};
        a_e   = {{(EW-ACT_W){1'b0}}, act};
        neg_e = -p_e;
        rem_e = '0;
        skip  = '0;
        start = pos;
        vis   = dim;
        if (p_e < 0) begin
            skip  = neg_e[POS_W-1:0];
            start = '0;
            rem_e = d_e - neg_e;
            vis   = (neg_e >= d_e) ? '0 : rem_e[DIM_W-1:0];
        end else if (p_e + d_e > a_e) begin
            rem_e = a_e - p_e;
            vis   = (rem_e <= 0) ? '0 : rem_e[DIM_W-1:0];
        end
    end
endmodule

// File: rtl/cursor_commit_ctrl.sv
module cursor_commit_ctrl
    import cursor_clip_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_valid,
    input  req_kind_t  kind,
    input  pos_word_t  new_pos,
    input  size_word_t new_size,
    input  logic       frame_done,
    output pos_word_t  hw_pos,
    output size_word_t hw_size,
    output logic       hw_enable,
    output logic       pending,
    output logic       reload_req,
    output logic       size_reject
);
    pos_word_t  arm_pos;
    size_word_t arm_size;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_pos     <= '0;
            arm_size    <= '0;
            hw_pos      <= '0;
            hw_size     <= '0;
            hw_enable   <= 1'b0;
            pending     <= 1'b0;
            reload_req  <= 1'b0;
            size_reject <= 1'b0;
        end else begin
            reload_req  <= 1'b0;
            size_reject <= 1'b0;
            if (frame_done && pending) begin
                hw_pos    <= arm_pos;
                hw_size   <= arm_size;
                hw_enable <= 1'b1;
                pending   <= 1'b0;
            end
            if (upd_valid) begin
                case (kind)
                    REQ_REJECT: size_reject <= 1'b1;
                    REQ_DISABLE: begin
                        hw_enable <= 1'b0;
                        pending   <= 1'b0;
                    end
                    REQ_ARM: begin
                        arm_pos  <= new_pos;
                        arm_size <= new_size;
                        pending  <= 1'b1;
                        if (new_size != arm_size) begin
                            hw_enable  <= 1'b0;
                            reload_req <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cursor_clip_top.sv
module cursor_clip_top
    import cursor_clip_pkg::*;
#(
    parameter int POS_W      = 16,
    parameter int DIM_W      = 7,
    parameter int ACT_W      = 12,
    parameter int MAX_SIDE   = 64,
    parameter int NARROW_MAX = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd_valid,
    input  logic                    img_present,
    input  logic                    interlaced,
    input  logic signed [POS_W-1:0] cur_x,
    input  logic signed [POS_W-1:0] cur_y,
    input  logic [DIM_W-1:0]        bmp_w,
    input  logic [DIM_W-1:0]        bmp_h,
    input  logic [ACT_W-1:0]        act_w,
    input  logic [ACT_W-1:0]        act_h,
    input  logic                    frame_done,
    output logic [31:0]             hw_pos,
    output logic [31:0]             hw_size,
    output logic                    hw_enable,
    output logic                    upd_pending,
    output logic                    reload_req,
    output logic                    size_reject,
    output logic [POS_W-1:0]        bmp_xoff,
    output logic [POS_W-1:0]        bmp_yoff,
    output logic [DIM_W:0]          bmp_stride
);
    localparam int AXES = 2;

    logic signed [POS_W-1:0] ax_pos  [AXES];
    logic [DIM_W-1:0]        ax_dim  [AXES];
    logic [ACT_W-1:0]        ax_act  [AXES];
    logic [POS_W-1:0]        ax_skip [AXES];
    logic [POS_W-1:0]        ax_start[AXES];
    logic [DIM_W-1:0]        ax_vis  [AXES];

    assign ax_pos[0] = cur_x;
    assign ax_pos[1] = cur_y;
    assign ax_dim[0] = bmp_w;
    assign ax_dim[1] = bmp_h;
    assign ax_act[0] = act_w;
    assign ax_act[1] = act_h;

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        cursor_axis_clip #(.POS_W(POS_W), .DIM_W(DIM_W), .ACT_W(ACT_W)) u_clip (
            .pos  (ax_pos[g]),
            .dim  (ax_dim[g]),
            .act  (ax_act[g]),
            .skip (ax_skip[g]),
            .start(ax_start[g]),
            .vis  (ax_vis[g])
        );
    end

    logic [POS_W-1:0] scr_y;
    logic [DIM_W-1:0] vis_h;
    logic [DIM_W:0]   stride_n;
    logic             legal;
    req_kind_t        kind;
    pos_word_t        pos_n;
    size_word_t       size_n;
    pos_word_t        pos_q;
    size_word_t       size_q;

    always_comb begin
        scr_y    = interlaced ? (ax_start[1] >> 1) : ax_start[1];
        vis_h    = interlaced ? (ax_vis[1] >> 1)   : ax_vis[1];
        stride_n = interlaced ? {bmp_w, 1'b0} : {1'b0, bmp_w};
        legal    = dims_fit(int'(bmp_w), int'(bmp_h), MAX_SIDE, NARROW_MAX);
        pos_n    = '{row: PACK_W'(scr_y), col: PACK_W'(ax_start[0])};
        size_n   = '{lines: PACK_W'(vis_h), pixels: PACK_W'(ax_vis[0])};
        if (img_present && !legal)
            kind = REQ_REJECT;
        else if (!img_present || ax_vis[0] == '0 || vis_h == '0)
            kind = REQ_DISABLE;
        else
            kind = REQ_ARM;
    end

    cursor_commit_ctrl u_commit (
        .clk        (clk),
        .rst        (rst),
        .upd_valid  (upd_valid),
        .kind       (kind),
        .new_pos    (pos_n),
        .new_size   (size_n),
        .frame_done (frame_done),
        .hw_pos     (pos_q),
        .hw_size    (size_q),
        .hw_enable  (hw_enable),
        .pending    (upd_pending),
        .reload_req (reload_req),
        .size_reject(size_reject)
    );

    assign hw_pos  = pos_q;
    assign hw_size = size_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bmp_xoff   <= '0;
            bmp_yoff   <= '0;
            bmp_stride <= '0;
        end else if (upd_valid && kind == REQ_ARM) begin
            bmp_xoff   <= ax_skip[0];
            bmp_yoff   <= ax_skip[1];
            bmp_stride <= stride_n;
        end
    end
endmodule

// File: rtl/cursor_clip_checker.sv
module cursor_clip_checker #(
    parameter int DIM_W      = 7,
    parameter int MAX_SIDE   = 64,
    parameter int NARROW_MAX = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             upd_valid,
    input logic             img_present,
    input logic [DIM_W-1:0] bmp_w,
    input logic [DIM_W-1:0] bmp_h,
    input logic             frame_done,
    input logic [31:0]      hw_pos,
    input logic [31:0]      hw_size,
    input logic             hw_enable,
    input logic             upd_pending,
    input logic             reload_req,
    input logic             size_reject
);
    logic oversized;
    assign oversized = (int'(bmp_w) > MAX_SIDE) || (int'(bmp_h) > MAX_SIDE) ||
                       ((int'(bmp_w) > NARROW_MAX) && (int'(bmp_h) > NARROW_MAX));

    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> !hw_enable && !upd_pending && !reload_req && !size_reject);

    assert_commit_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_done && upd_pending && !upd_valid) |=> hw_enable && !upd_pending);

    assert_hold_words_R8: assert property (@(posedge clk) disable iff (rst)
        !(frame_done && upd_pending) |=> $stable(hw_pos) && $stable(hw_size));

    assert_reject_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && img_present && oversized && !frame_done) |=>
        size_reject && $stable(upd_pending) && $stable(hw_enable));

    assert_no_image_off_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !img_present) |=> !hw_enable && !upd_pending);

    assert_reload_off_R9: assert property (@(posedge clk) disable iff (rst)
        reload_req |-> !hw_enable && upd_pending);

    assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reload_req, size_reject}));
endmodule

bind cursor_clip_top cursor_clip_checker #(
    .DIM_W(DIM_W), .MAX_SIDE(MAX_SIDE), .NARROW_MAX(NARROW_MAX)
) u_checker (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .img_present(img_present),
    .bmp_w(bmp_w), .bmp_h(bmp_h), .frame_done(frame_done),
    .hw_pos(hw_pos), .hw_size(hw_size), .hw_enable(hw_enable),
    .upd_pending(upd_pending), .reload_req(reload_req), .size_reject(size_reject)
);

// File: tb/cursor_clip_top_bench.sv
module cursor_clip_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    typedef struct packed {
        logic signed [15:0] x;
        logic signed [15:0] y;
        logic [6:0]  w;
        logic [6:0]  h;
        logic        il;
        logic        img;
        logic [1:0]  kind;   // 0 arm, 1 disable, 2 reject
        logic [31:0] pos;
        logic [31:0] size;
        logic [15:0] xoff;
        logic [15:0] yoff;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{16'sd100, 16'sd50,  7'd32, 7'd32, 1'b0, 1'b1, 2'd0, 32'h0032_0064, 32'h0020_0020, 16'd0,  16'd0},
        '{-16'sd10, 16'sd20,  7'd32, 7'd16, 1'b0, 1'b1, 2'd0, 32'h0014_0000, 32'h0010_0016, 16'd10, 16'd0},
        '{16'sd620, 16'sd470, 7'd32, 7'd32, 1'b0, 1'b1, 2'd0, 32'h01D6_026C, 32'h000A_0014, 16'd0,  16'd0},
        '{16'sd10,  -16'sd5,  7'd16, 7'd64, 1'b0, 1'b1, 2'd0, 32'h0000_000A, 32'h003B_0010, 16'd0,  16'd5},
        '{16'sd10,  16'sd101, 7'd16, 7'd32, 1'b1, 1'b1, 2'd0, 32'h0032_000A, 32'h0010_0010, 16'd0,  16'd0},
        '{16'sd10,  16'sd0,   7'd16, 7'd33, 1'b1, 1'b1, 2'd0, 32'h0000_000A, 32'h0010_0010, 16'd0,  16'd0},
        '{16'sd0,   16'sd0,   7'd48, 7'd48, 1'b0, 1'b1, 2'd2, 32'h0,         32'h0,         16'd0,  16'd0},
        '{16'sd0,   16'sd0,   7'd64, 7'd33, 1'b0, 1'b1, 2'd2, 32'h0,         32'h0,         16'd0,  16'd0},
        '{-16'sd40, 16'sd0,   7'd32, 7'd32, 1'b0, 1'b1, 2'd1, 32'h0,         32'h0,         16'd0,  16'd0},
        '{16'sd640, 16'sd0,   7'd8,  7'd8,  1'b0, 1'b1, 2'd1, 32'h0,         32'h0,         16'd0,  16'd0},
        '{16'sd5,   16'sd5,   7'd8,  7'd8,  1'b0, 1'b0, 2'd1, 32'h0,         32'h0,         16'd0,  16'd0},
        '{16'sd0,   16'sd0,   7'd1,  7'd1,  1'b1, 1'b1, 2'd1, 32'h0,         32'h0,         16'd0,  16'd0},
        '{-16'sd5,  -16'sd3,  7'd64, 7'd32, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 32'h001D_003B, 16'd5,  16'd3},
        '{16'sd608, 16'sd448, 7'd32, 7'd32, 1'b0, 1'b1, 2'd0, 32'h01C0_0260, 32'h0020_0020, 16'd0,  16'd0}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               upd_valid = 1'b0;
    logic               img_present = 1'b0;
    logic               interlaced = 1'b0;
    logic signed [15:0] cur_x = '0;
    logic signed [15:0] cur_y = '0;
    logic [6:0]         bmp_w = '0;
    logic [6:0]         bmp_h = '0;
    logic [11:0]        act_w = 12'd640;
    logic [11:0]        act_h = 12'd480;
    logic               frame_done = 1'b0;
    logic [31:0]        hw_pos;
    logic [31:0]        hw_size;
    logic               hw_enable;
    logic               upd_pending;
    logic               reload_req;
    logic               size_reject;
    logic [15:0]        bmp_xoff;
    logic [15:0]        bmp_yoff;
    logic [7:0]         bmp_stride;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cursor_clip_top u_cursor_clip_top (
        .clk(clk), .rst(rst), .upd_valid(upd_valid), .img_present(img_present),
        .interlaced(interlaced), .cur_x(cur_x), .cur_y(cur_y), .bmp_w(bmp_w),
        .bmp_h(bmp_h), .act_w(act_w), .act_h(act_h), .frame_done(frame_done),
        .hw_pos(hw_pos), .hw_size(hw_size), .hw_enable(hw_enable),
        .upd_pending(upd_pending), .reload_req(reload_req), .size_reject(size_reject),
        .bmp_xoff(bmp_xoff), .bmp_yoff(bmp_yoff), .bmp_stride(bmp_stride)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic request(input logic signed [15:0] x, input logic signed [15:0] y,
                           input logic [6:0] w, input logic [6:0] h,
                           input logic il, input logic img, input logic fd);
        @(negedge clk);
        cur_x = x; cur_y = y; bmp_w = w; bmp_h = h;
        interlaced = il; img_present = img;
        upd_valid = 1'b1; frame_done = fd;
        @(negedge clk);
        upd_valid = 1'b0; frame_done = 1'b0;
    endtask

    task automatic frame_strobe();
        @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] prev_pos, prev_size, last_arm;
        logic        prev_en, exp_reload;

        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 pos", hw_pos, 32'h0);
        check("R11 size", hw_size, 32'h0);
        check("R11 flags", {28'h0, hw_enable, upd_pending, reload_req, size_reject}, 32'h0);
        check("R11 offsets", {bmp_xoff, bmp_yoff}, 32'h0);
        check("R11 stride", {24'h0, bmp_stride}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R8: frame_done with nothing pending changes nothing
        frame_strobe();
        check("R8 idle frame enable", {31'h0, hw_enable}, 32'h0);

        prev_pos = 32'h0; prev_size = 32'h0; prev_en = 1'b0; last_arm = 32'h0;

        for (int i = 0; i < NV; i++) begin
            request(VECS[i].x, VECS[i].y, VECS[i].w, VECS[i].h, VECS[i].il, VECS[i].img, 1'b0);
            case (VECS[i].kind)
                2'd0: begin
                    exp_reload = (VECS[i].size != last_arm);
                    // R9
                    check("R9 reload", {31'h0, reload_req}, {31'h0, exp_reload});
                    check("R9 enable after request", {31'h0, hw_enable},
                          {31'h0, exp_reload ? 1'b0 : prev_en});
                    check("R8 pending set", {31'h0, upd_pending}, 32'h1);
                    check("R8 pos held", hw_pos, prev_pos);
                    // R1 R3 offsets, R4 stride
                    check("R1 R3 offsets", {bmp_xoff, bmp_yoff}, {VECS[i].xoff, VECS[i].yoff});
                    check("R4 stride", {24'h0, bmp_stride},
                          {24'h0, VECS[i].il ? {VECS[i].w, 1'b0} : {1'b0, VECS[i].w}});
                    last_arm = VECS[i].size;
                    frame_strobe();
                    // R7 R2 R3 R4 packed results
                    check("R7 R1 R2 pos", hw_pos, VECS[i].pos);
                    check("R7 R3 R4 size", hw_size, VECS[i].size);
                    check("R8 commit", {30'h0, hw_enable, upd_pending}, 32'h2);
                    prev_pos = VECS[i].pos; prev_size = VECS[i].size; prev_en = 1'b1;
                end
                2'd1: begin
                    check("R5 disable", {30'h0, hw_enable, upd_pending}, 32'h0);
                    frame_strobe();
                    check("R5 stays off", {31'h0, hw_enable}, 32'h0);
                    check("R5 pos kept", hw_pos, prev_pos);
                    prev_en = 1'b0;
                end
                default: begin
                    check("R6 reject pulse", {31'h0, size_reject}, 32'h1);
                    check("R6 state kept", {30'h0, hw_enable, upd_pending}, {30'h0, prev_en, 1'b0});
                    check("R6 size kept", hw_size, prev_size);
                end
            endcase
        end

        // R10: resized request meets frame_done with an armed update
        request(16'sd0, 16'sd0, 7'd16, 7'd16, 1'b0, 1'b1, 1'b0);
        check("R9 reload before R10", {31'h0, reload_req}, 32'h1);
        request(16'sd1, 16'sd2, 7'd8, 7'd8, 1'b0, 1'b1, 1'b1);
        check("R10 old pos", hw_pos, 32'h0000_0000);
        check("R10 old size", hw_size, 32'h0010_0010);
        check("R10 flags", {29'h0, hw_enable, upd_pending, reload_req}, 32'h3);
        frame_strobe();
        check("R10 new pos", hw_pos, 32'h0002_0001);
        check("R10 new size", hw_size, 32'h0008_0008);
        check("R10 enabled", {31'h0, hw_enable}, 32'h1);

        // R10: disable request meets frame_done with an armed update
        request(16'sd3, 16'sd3, 7'd8, 7'd8, 1'b0, 1'b1, 1'b0);
        check("R9 same size no reload", {30'h0, reload_req, hw_enable}, 32'h1);
        request(16'sd3, 16'sd3, 7'd8, 7'd8, 1'b0, 1'b0, 1'b1);
        check("R10 disable commit pos", hw_pos, 32'h0003_0003);
        check("R10 disable flags", {30'h0, hw_enable, upd_pending}, 32'h0);
        frame_strobe();
        check("R8 no pending stays off", {31'h0, hw_enable}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule